// File: doc/BRIEF.md
# Lookahead Head-Cache Refill Scheduler

This block schedules refills of a small per-queue head cache that sits in front of a slow bulk memory. The bulk memory holds the middle of several FIFOs and returns B cells of one queue per access on a single shared address. The downstream arbiter is allowed a fixed delay. Each slot it may issue one read request, a valid bit plus a queue number. The scheduler holds these requests in a lookahead line of NQ*(B-1)+1 slots. Every request is released as a dispatch exactly that many slots after it arrived.

Once every B slots the scheduler compares the pending requests in the line with how many cells each queue has cached. It picks the queue whose demand first overtakes its cached cells and issues one bulk read command for B cells of that queue. The cached count is raised as soon as the command is issued, so a shortfall is covered once. Per-queue counters track cached cells, and a sticky flag records any dispatch made from an empty queue. The cell payload path and the real memory timing are not part of the block.

Top module: `ecqf_refill_sched`

## Requirements
- R1: A request accepted at a clock edge (req_valid high) appears as disp_valid high, with disp_qid equal to its req_qid, exactly W = NQ*(B-1)+1 clock edges later.
- R2: A slot with req_valid low produces no dispatch W edges later. disp_valid is never high without a matching earlier request.
- R3: Read commands (rd_valid) are issued only on decision edges. The first edge after reset is a decision edge, and after it every B-th edge is one. rd_valid lasts one cycle.
- R4: At a decision, each queue is scanned from its oldest pending request to its newest. A queue becomes critical at the first position where its running request count exceeds its cached count, and the queue with the earliest such position is named in rd_qid.
- R5: If no queue becomes critical within the lookahead line, no read command is issued at that decision.
- R6: An issued read adds B cells to that queue's cached count at once. One request to an empty queue, followed by idle slots, causes exactly one read for that queue.
- R7: underflow is set when a dispatch leaves a queue whose cached count, including a refill issued on the same edge, is zero. It stays set until reset. Under the scheduling rule it is never raised by any request stream, including random ones.
- R8: With NQ=4 and B=4, after reset a round-robin request stream (queue 0, 1, 2, 3, repeating from the first edge) produces its first four reads for queues 0, 1, 2 and 3 in that order.
- R9: After reset, disp_valid, rd_valid and underflow are low and all cached counts are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slot clock, one cell slot per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Arbiter request present this slot |
| req_qid | input | $clog2(NQ) | Queue named by the request |
| disp_valid | output | 1 | A cell is dispatched this slot |
| disp_qid | output | $clog2(NQ) | Queue of the dispatched cell |
| rd_valid | output | 1 | Bulk read command of B cells issued |
| rd_qid | output | $clog2(NQ) | Queue refilled by the read command |
| underflow | output | 1 | Sticky: a dispatch found its queue empty |

## Verification
A corrupted cached count shows up at the next decision edge, within B slots. It either makes rd_qid name a different queue or makes a needed read disappear. A read that goes missing later raises underflow within at most W slots. A lookahead line that loses or reorders an entry shows up W slots after the faulty request, as a missing, extra or mislabelled dispatch. The same fault also changes which queue the next decision picks. A phase fault in the decision counter shows as rd_valid on an edge outside the B-slot grid.

// File: rtl/ecqf_pkg.sv
package ecqf_pkg;

  // Slots between a request entering and its cell leaving.
  function automatic int win_len(input int nq, input int b);
    return nq * (b - 1) + 1;
  endfunction

  // Total cells the head cache must be able to hold.
  function automatic int cache_cap(input int nq, input int b);
    return nq * (b - 1);
  endfunction

  // Width of a cached-cell counter: a refill is ordered only while the
  // count is below the window demand, so it stays under win + b.
  function automatic int cnt_width(input int nq, input int b);
    return $clog2(win_len(nq, b) + b) + 1;
  endfunction

  // True when the demand seen so far outruns what is cached.
  function automatic logic runs_dry(input logic [15:0] demand, input logic [15:0] cached);
    return demand > cached;
  endfunction

endpackage

// File: rtl/ecqf_lookahead.sv
module ecqf_lookahead #(
  parameter int W  = 13,
  parameter int QW = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  input  logic [QW-1:0]         in_qid,
  output logic [W-1:0]          win_valid,
  output logic [W-1:0][QW-1:0]  win_qid
);
  // Stage 0 holds the newest request, stage W-1 the oldest.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_valid[0] <= 1'b0;
      win_qid[0]   <= '0;
    end else begin
      win_valid[0] <= in_valid;
      win_qid[0]   <= in_qid;
    end
  end

  for (genvar s = 1; s < W; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        win_valid[s] <= 1'b0;
        win_qid[s]   <= '0;
      end else begin
        win_valid[s] <= win_valid[s-1];
        win_qid[s]   <= win_qid[s-1];
      end
    end
  end
endmodule

// File: rtl/ecqf_crit_finder.sv
module ecqf_crit_finder
  import ecqf_pkg::*;
#(
  parameter int NQ = 4,
  parameter int W  = 13,
  parameter int QW = 2,
  parameter int CW = 6
) (
  input  logic [W-1:0]          win_valid,
  input  logic [W-1:0][QW-1:0]  win_qid,
  input  logic [NQ-1:0][CW-1:0] cached,
  output logic                  found,
  output logic [QW-1:0]         sel_qid
);
  localparam int PSW = (W > 1) ? $clog2(W) : 1;

  logic [NQ-1:0]          q_hit;
  logic [NQ-1:0][PSW-1:0] q_pos;

  for (genvar q = 0; q < NQ; q++) begin : g_queue
    logic [CW-1:0]  acc;
    logic           hit_l;
    logic [PSW-1:0] pos_l;

    // Walk oldest to newest; record first slot where demand beats cache.
    always_comb begin
      acc   = '0;
      hit_l = 1'b0;
      pos_l = '0;
      for (int p = 0; p < W; p++) begin
        if (win_valid[W-1-p] && (win_qid[W-1-p] == QW'(q))) acc = acc + CW'(1);
        if (!hit_l && runs_dry(16'(acc), 16'(cached[q]))) begin
          hit_l = 1'b1;
          pos_l = PSW'(p);
        end
      end
    end

    assign q_hit[q] = hit_l;
    assign q_pos[q] = pos_l;
  end

  // Earliest position wins; strict compare keeps the lowest index on ties.
  logic [PSW-1:0] best_pos;
  always_comb begin
    found    = 1'b0;
    sel_qid  = '0;
    best_pos = '0;
    for (int q = 0; q < NQ; q++) begin
      if (q_hit[q] && (!found || (q_pos[q] < best_pos))) begin
        found    = 1'b1;
        sel_qid  = QW'(q);
        best_pos = q_pos[q];
      end
    end
  end
endmodule

// File: rtl/ecqf_occupancy.sv
module ecqf_occupancy #(
  parameter int NQ = 4,
  parameter int B  = 4,
  parameter int QW = 2,
  parameter int CW = 6
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  fill_valid,
  input  logic [QW-1:0]         fill_qid,
  input  logic                  take_valid,
  input  logic [QW-1:0]         take_qid,
  output logic [NQ-1:0][CW-1:0] cached,
  output logic                  empty_take,
  output logic                  underflow
);
  logic [NQ-1:0] dry_evt;

  for (genvar q = 0; q < NQ; q++) begin : g_cnt
    logic          fill_here;
    logic          take_here;
    logic [CW-1:0] after_fill;

    assign fill_here  = fill_valid && (fill_qid == QW'(q));
    assign take_here  = take_valid && (take_qid == QW'(q));
    assign after_fill = cached[q] + (fill_here ? CW'(B) : CW'(0));
    assign dry_evt[q] = take_here && (after_fill == '0);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        cached[q] <= '0;
      else if (take_here && (after_fill != '0))
        cached[q] <= after_fill - CW'(1);
      else
        cached[q] <= after_fill;
    end
  end

  assign empty_take = |dry_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          underflow <= 1'b0;
    else if (empty_take) underflow <= 1'b1;
  end
endmodule

// File: rtl/ecqf_refill_sched.sv
module ecqf_refill_sched
  import ecqf_pkg::*;
#(
  parameter int NQ = 4,
  parameter int B  = 4,
  localparam int QW = $clog2(NQ)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [QW-1:0] req_qid,
  output logic          disp_valid,
  output logic [QW-1:0] disp_qid,
  output logic          rd_valid,
  output logic [QW-1:0] rd_qid,
  output logic          underflow
);
  localparam int W   = win_len(NQ, B);
  localparam int CW  = cnt_width(NQ, B);
  localparam int PHW = (B > 1) ? $clog2(B) : 1;

  logic [W-1:0]          win_valid;
  logic [W-1:0][QW-1:0]  win_qid;
  logic [NQ-1:0][CW-1:0] cached;
  logic                  crit_found;
  logic [QW-1:0]         crit_qid;
  logic                  head_valid;
  logic [QW-1:0]         head_qid;
  logic                  decide_slot;
  logic                  refill_fire;
  logic                  empty_take;
  logic [PHW-1:0]        phase;

  ecqf_lookahead #(.W(W), .QW(QW)) u_look (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (req_valid),
    .in_qid    (req_qid),
    .win_valid (win_valid),
    .win_qid   (win_qid)
  );

  assign head_valid = win_valid[W-1];
  assign head_qid   = win_qid[W-1];

  ecqf_crit_finder #(.NQ(NQ), .W(W), .QW(QW), .CW(CW)) u_crit (
    .win_valid (win_valid),
    .win_qid   (win_qid),
    .cached    (cached),
    .found     (crit_found),
    .sel_qid   (crit_qid)
  );

  // Decision grid: phase 0 is a decision edge, one in every B slots.
  assign decide_slot = (phase == '0);
  assign refill_fire = decide_slot && crit_found;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     phase <= '0;
    else if (phase == PHW'(B - 1))  phase <= '0;
    else                            phase <= phase + PHW'(1);
  end

  ecqf_occupancy #(.NQ(NQ), .B(B), .QW(QW), .CW(CW)) u_occ (
    .clk        (clk),
    .rst_n      (rst_n),
    .fill_valid (refill_fire),
    .fill_qid   (crit_qid),
    .take_valid (head_valid),
    .take_qid   (head_qid),
    .cached     (cached),
    .empty_take (empty_take),
    .underflow  (underflow)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      disp_valid <= 1'b0;
      disp_qid   <= '0;
      rd_valid   <= 1'b0;
      rd_qid     <= '0;
    end else begin
      disp_valid <= head_valid;
      disp_qid   <= head_qid;
      rd_valid   <= refill_fire;
      rd_qid     <= refill_fire ? crit_qid : rd_qid;
    end
  end
endmodule

// File: rtl/ecqf_refill_sched_chk.sv
module ecqf_refill_sched_chk #(
  parameter int QW = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          head_valid,
  input logic [QW-1:0] head_qid,
  input logic          decide_slot,
  input logic          crit_found,
  input logic [QW-1:0] crit_qid,
  input logic          empty_take,
  input logic          disp_valid,
  input logic [QW-1:0] disp_qid,
  input logic          rd_valid,
  input logic [QW-1:0] rd_qid,
  input logic          underflow
);
  assert_head_dispatched_R1: assert property (@(posedge clk) disable iff (!rst_n)
    head_valid |=> (disp_valid && (disp_qid == $past(head_qid))));

  assert_idle_no_dispatch_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !head_valid |=> !disp_valid);

  assert_read_on_grid_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !decide_slot |=> !rd_valid);

  assert_decision_spacing_R3: assert property (@(posedge clk) disable iff (!rst_n)
    decide_slot |=> !decide_slot);

  assert_critical_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (decide_slot && crit_found) |=> (rd_valid && (rd_qid == $past(crit_qid))));

  assert_no_read_without_need_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !crit_found |=> !rd_valid);

  assert_underflow_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    underflow |=> underflow);

  assert_underflow_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!underflow && !empty_take) |=> !underflow);
endmodule

bind ecqf_refill_sched ecqf_refill_sched_chk #(.QW(QW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .head_valid  (head_valid),
  .head_qid    (head_qid),
  .decide_slot (decide_slot),
  .crit_found  (crit_found),
  .crit_qid    (crit_qid),
  .empty_take  (empty_take),
  .disp_valid  (disp_valid),
  .disp_qid    (disp_qid),
  .rd_valid    (rd_valid),
  .rd_qid      (rd_qid),
  .underflow   (underflow)
);

// File: tb/ecqf_refill_sched_tb.sv
module ecqf_refill_sched_tb;
  localparam int NQ = 4;
  localparam int B  = 4;
  localparam int QW = 2;
  localparam int W  = NQ * (B - 1) + 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic [QW-1:0] req_qid = '0;
  logic          disp_valid;
  logic [QW-1:0] disp_qid;
  logic          rd_valid;
  logic [QW-1:0] rd_qid;
  logic          underflow;

  always #5 clk = ~clk;

  ecqf_refill_sched #(.NQ(NQ), .B(B)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_qid(req_qid),
    .disp_valid(disp_valid), .disp_qid(disp_qid),
    .rd_valid(rd_valid), .rd_qid(rd_qid), .underflow(underflow)
  );

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  bit done = 0;

  typedef struct { int qid; int due; } ent_t;
  ent_t sb[$];
  int   rd_log[$];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Reference model of the refill rule, written per request slot.
  int  m_win_v[W];
  int  m_win_q[W];
  int  m_cnt[NQ];
  int  m_phase;
  bit  exp_rd_v;
  int  exp_rd_q;

  function automatic int pick_queue();
    int seen[NQ];
    for (int q = 0; q < NQ; q++) seen[q] = 0;
    for (int p = W - 1; p >= 0; p--) begin
      if (m_win_v[p] != 0) begin
        seen[m_win_q[p]]++;
        if (seen[m_win_q[p]] > m_cnt[m_win_q[p]]) return m_win_q[p];
      end
    end
    return -1;
  endfunction

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst_n) begin
      for (int i = 0; i < W; i++) begin m_win_v[i] = 0; m_win_q[i] = 0; end
      for (int q = 0; q < NQ; q++) m_cnt[q] = 0;
      m_phase  = 0;
      exp_rd_v = 0;
      exp_rd_q = 0;
    end else begin
      int pick;
      pick = (m_phase == 0) ? pick_queue() : -1;
      exp_rd_v = (pick >= 0);
      if (pick >= 0) begin exp_rd_q = pick; m_cnt[pick] += B; end
      if (m_win_v[W-1] != 0 && m_cnt[m_win_q[W-1]] > 0) m_cnt[m_win_q[W-1]]--;
      for (int i = W - 1; i > 0; i--) begin
        m_win_v[i] = m_win_v[i-1];
        m_win_q[i] = m_win_q[i-1];
      end
      m_win_v[0] = req_valid ? 1 : 0;
      m_win_q[0] = int'(req_qid);
      m_phase = (m_phase + 1) % B;
    end
  end

  // Monitor: pops the dispatch scoreboard and compares reads with the model.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (disp_valid) begin
        if (sb.size() == 0) chk(0, "R2 dispatch without request", int'(disp_qid), -1);
        else begin
          ent_t e;
          e = sb.pop_front();
          chk(disp_qid == QW'(e.qid), "R1 dispatch queue", int'(disp_qid), e.qid);
          chk(cyc == e.due, "R1 dispatch latency", cyc, e.due);
        end
      end else if (sb.size() > 0 && sb[0].due == cyc) begin
        chk(0, "R1 missing dispatch", 0, 1);
        void'(sb.pop_front());
      end
      if (exp_rd_v)
        chk(rd_valid && rd_qid == QW'(exp_rd_q), "R4 R6 refill choice",
            rd_valid ? int'(rd_qid) : -1, exp_rd_q);
      else
        chk(!rd_valid, "R3 R5 unexpected read", int'(rd_valid), 0);
      if (rd_valid) rd_log.push_back(int'(rd_qid));
    end
  end

  task automatic send(input bit v, input int q);
    @(negedge clk);
    req_valid = v;
    req_qid   = QW'(q);
    if (v) begin
      ent_t e;
      e.qid = q;
      e.due = cyc + 1 + W;
      sb.push_back(e);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) send(0, 0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    req_valid = 1'b0;
    repeat (3) @(negedge clk);
    sb.delete();
    rd_log.delete();
    rst_n = 1'b1;
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      tests++;
      $display("FAIL R1 watchdog expired actual=%0d expected=%0d", cyc, 0);
      summary();
      $finish;
    end
  end

  initial begin
    do_reset();
    #1;
    chk(disp_valid == 0, "R9 reset disp_valid", int'(disp_valid), 0);
    chk(rd_valid == 0, "R9 reset rd_valid", int'(rd_valid), 0);
    chk(underflow == 0, "R9 reset underflow", int'(underflow), 0);

    // R6: one request to an empty queue gives exactly one refill.
    send(1, 2);
    idle(30);
    chk(rd_log.size() == 1, "R6 single refill count", rd_log.size(), 1);
    if (rd_log.size() > 0) chk(rd_log[0] == 2, "R6 refill queue", rd_log[0], 2);

    // R5: idle window with cached cells left over issues nothing.
    rd_log.delete();
    idle(20);
    chk(rd_log.size() == 0, "R5 no read when nothing critical", rd_log.size(), 0);

    // R4: oldest shortfall wins over a queue with more pending requests.
    do_reset();
    send(1, 3);
    for (int i = 0; i < 3; i++) send(1, 1);
    idle(8);
    chk(rd_log.size() >= 2, "R4 reads issued", rd_log.size(), 2);
    if (rd_log.size() >= 2) begin
      chk(rd_log[0] == 3, "R4 earliest critical first", rd_log[0], 3);
      chk(rd_log[1] == 1, "R4 next critical", rd_log[1], 1);
    end
    idle(W + 2);

    // R8: round-robin stream refills queues in turn.
    do_reset();
    for (int i = 0; i < 48; i++) send(1, i % NQ);
    idle(W + 4);
    chk(rd_log.size() >= 4, "R8 read count", rd_log.size(), 4);
    for (int k = 0; k < 4; k++)
      if (rd_log.size() > k) chk(rd_log[k] == k, "R8 rotation order", rd_log[k], k);

    // R7: random streams never empty a queue at dispatch.
    do_reset();
    for (int i = 0; i < 3000; i++) send(($urandom % 5) != 0, int'($urandom % NQ));
    idle(W + 4);
    chk(underflow == 0, "R7 underflow never raised", int'(underflow), 0);
    chk(sb.size() == 0, "R1 scoreboard drained", sb.size(), 0);

    done = 1;
    summary();
    $finish;
  end
endmodule